// File: doc/BRIEF.md
# Double-Buffered Pulse and Interval Timer

This block is a 16-bit up-counting timer built around two compare values, A and B. The counter advances only on cycles where the count-enable tick is high and the timer is running. When the count equals B, that count is the last one of the period, and on the next tick the counter returns to zero. Each period is therefore B+1 ticks long. A count equal to A or to B raises a one-cycle match interrupt, and each interrupt has its own enable.

The timer has two modes. In interval mode it only produces the periodic B interrupt, and the output pin stays at its idle level. In pulse mode an output flip-flop inverts on the A match and again on the B match, which gives a square wave whose period and duty ratio software sets. A polarity input selects whether the active part of the wave is high or low.

Compare A can be double-buffered. With buffering on, a write lands in a shadow register and reaches the active compare only at the B match, so the duty ratio changes cleanly at a period boundary. With buffering off, a write to A takes effect at once.

Top module: `ppg_timer`

## Requirements
- R1: The counter starts at zero and advances by one on each cycle where run_i and tick_i are both high. On such a tick with the count equal to compare B it returns to zero, so a period lasts B+1 ticks. A cycle without a tick leaves the count unchanged.
- R2: While run_i is low the counter is held at zero and pulse_o sits at its idle level. Raising run_i starts counting again from zero.
- R3: In pulse mode (mode_i=1) the flip-flop inverts on every tick where the count equals A and on every tick where it equals B. With A < B, pulse_o is at its active level for exactly B-A of the B+1 samples in each period.
- R4: pol_i=0 gives an idle level of 0 and an active level of 1. pol_i=1 reverses both levels.
- R5: In interval mode (mode_i=0) pulse_o stays at its idle level, and irq_b_o fires once every B+1 ticks. With a tick on every other cycle, the first irq_b_o after start appears after the edge of the (B+1)-th tick.
- R6: irq_a_o and irq_b_o are high for the one cycle after a tick whose count matched A or B, and only when irq_en_a_i or irq_en_b_i respectively is high.
- R7: A write to A (wr_a_i) with dbuf_en_i=0 changes the active compare A at that clock edge.
- R8: A write to A with dbuf_en_i=1 only fills the shadow register. The shadow value becomes the active A on the tick that matches B, so the current period still uses the old A.
- R9: Register writes on cycles without a tick never invert pulse_o and never raise an interrupt.
- R10: Synchronous reset (rst=1) clears pulse_o, irq_a_o, irq_b_o, the counter and both compare values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_i | input | 1 | Count enable, one tick per high cycle |
| run_i | input | 1 | 1 = count, 0 = stop and clear |
| mode_i | input | 1 | 0 = interval, 1 = pulse |
| pol_i | input | 1 | Output polarity; 1 selects idle-high |
| dbuf_en_i | input | 1 | Route compare A writes through the shadow register |
| wr_a_i | input | 1 | Write strobe for compare A |
| wr_b_i | input | 1 | Write strobe for compare B |
| wr_data_i | input | 16 | Write data for either compare |
| irq_en_a_i | input | 1 | Enable for match A interrupt |
| irq_en_b_i | input | 1 | Enable for match B interrupt |
| pulse_o | output | 1 | Registered square-wave output |
| irq_a_o | output | 1 | One-cycle match A interrupt |
| irq_b_o | output | 1 | One-cycle match B interrupt |

## Verification
The assertions assume that every input is synchronous to clk. The pulse-mode duty checks also depend on compare A being strictly below compare B, because an equal pair would cancel both inversions. Software writes compare values only while the timer is stopped, or with buffering on, so that the active A never passes the running count in the middle of a period. The stimulus follows these rules. Every configuration in the vector table has A < B. Every direct write in the bench happens with run_i low or with dbuf_en_i high. The single exception is the no-tick write test, where no tick can reach the compare logic.

// File: rtl/ppg_pkg.sv
package ppg_pkg;
  typedef enum logic {
    MODE_INTERVAL = 1'b0,
    MODE_PULSE    = 1'b1
  } ppg_mode_t;

  // Qualified compare hits: set only on a counting tick.
  typedef struct packed {
    logic hit_a;
    logic hit_b;
  } match_evt_t;
endpackage

// File: rtl/ppg_compare_regs.sv
module ppg_compare_regs #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         wr_a,
  input  logic         wr_b,
  input  logic [W-1:0] wr_data,
  input  logic         dbuf_en,
  input  logic         load,
  output logic [W-1:0] cmp_a_o,
  output logic [W-1:0] cmp_b_o
);
  logic [W-1:0] shadow_q;
  logic [W-1:0] act_a_q;
  logic [W-1:0] act_b_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      shadow_q <= '0;
      act_a_q  <= '0;
      act_b_q  <= '0;
    end else begin
      if (wr_a) shadow_q <= wr_data;
      if (wr_a && !dbuf_en)
        act_a_q <= wr_data;
      else if (load && dbuf_en)
        act_a_q <= shadow_q;
      if (wr_b) act_b_q <= wr_data;
    end
  end

  assign cmp_a_o = act_a_q;
  assign cmp_b_o = act_b_q;

  // R7: direct write lands at the edge
  assert_direct_write_R7: assert property (@(posedge clk) disable iff (rst)
    (wr_a && !dbuf_en) |=> (cmp_a_o == $past(wr_data)));

  // R8: buffered write leaves the active compare alone until the period boundary
  assert_shadow_hold_R8: assert property (@(posedge clk) disable iff (rst)
    (wr_a && dbuf_en && !load) |=> $stable(cmp_a_o));
endmodule

// File: rtl/ppg_counter.sv
module ppg_counter
  import ppg_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         run,
  input  logic         tick,
  input  logic [W-1:0] cmp_a,
  input  logic [W-1:0] cmp_b,
  output match_evt_t   evt_o
);
  logic [W-1:0] cnt_q;
  logic         step;
  logic         at_end;

  assign step   = run && tick;
  assign at_end = (cnt_q == cmp_b);

  always_ff @(posedge clk) begin
    if (rst || !run)
      cnt_q <= '0;
    else if (tick)
      cnt_q <= at_end ? '0 : cnt_q + 1'b1;
  end

  always_comb begin
    evt_o.hit_a = step && (cnt_q == cmp_a);
    evt_o.hit_b = step && at_end;
  end

  // R2: stopped counter sits at zero
  assert_stop_clears_R2: assert property (@(posedge clk) disable iff (rst)
    !run |=> (cnt_q == '0));

  // R1: end-of-period tick returns to zero
  assert_period_wrap_R1: assert property (@(posedge clk) disable iff (rst)
    (run && tick && (cnt_q == cmp_b)) |=> (cnt_q == '0));

  // R1: no tick, no movement
  assert_hold_no_tick_R1: assert property (@(posedge clk) disable iff (rst)
    (run && !tick) |=> $stable(cnt_q));
endmodule

// File: rtl/ppg_out_stage.sv
module ppg_out_stage
  import ppg_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       run,
  input  ppg_mode_t  mode,
  input  logic       pol,
  input  match_evt_t evt,
  input  logic       irq_en_a,
  input  logic       irq_en_b,
  output logic       pulse_o,
  output logic       irq_a_o,
  output logic       irq_b_o
);
  logic ff_q;
  logic irq_a_q;
  logic irq_b_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      ff_q    <= 1'b0;
      irq_a_q <= 1'b0;
      irq_b_q <= 1'b0;
    end else begin
      if (!run || mode != MODE_PULSE)
        ff_q <= pol;
      else if (evt.hit_a ^ evt.hit_b)
        ff_q <= ~ff_q;
      irq_a_q <= evt.hit_a && irq_en_a;
      irq_b_q <= evt.hit_b && irq_en_b;
    end
  end

  assign pulse_o = ff_q;
  assign irq_a_o = irq_a_q;
  assign irq_b_o = irq_b_q;

  // R2: stopped output shows the idle level
  assert_stop_idle_R2: assert property (@(posedge clk) disable iff (rst)
    !run |=> (pulse_o == $past(pol)));

  // R5: interval mode never drives the pin away from idle
  assert_interval_idle_R5: assert property (@(posedge clk) disable iff (rst)
    (mode == MODE_INTERVAL) |=> (pulse_o == $past(pol)));

  // R6: interrupts only when enabled
  assert_irq_a_gate_R6: assert property (@(posedge clk) disable iff (rst)
    irq_a_o |-> $past(irq_en_a));
  assert_irq_b_gate_R6: assert property (@(posedge clk) disable iff (rst)
    irq_b_o |-> $past(irq_en_b));

  // R9: running pulse output moves only on a compare hit
  assert_no_spurious_toggle_R9: assert property (@(posedge clk) disable iff (rst)
    (run && mode == MODE_PULSE && !evt.hit_a && !evt.hit_b) |=> $stable(pulse_o));
endmodule

// File: rtl/ppg_timer.sv
module ppg_timer
  import ppg_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         tick_i,
  input  logic         run_i,
  input  logic         mode_i,
  input  logic         pol_i,
  input  logic         dbuf_en_i,
  input  logic         wr_a_i,
  input  logic         wr_b_i,
  input  logic [W-1:0] wr_data_i,
  input  logic         irq_en_a_i,
  input  logic         irq_en_b_i,
  output logic         pulse_o,
  output logic         irq_a_o,
  output logic         irq_b_o
);
  logic [W-1:0] cmp_a;
  logic [W-1:0] cmp_b;
  match_evt_t   evt;
  ppg_mode_t    mode;

  assign mode = ppg_mode_t'(mode_i);

  ppg_compare_regs #(.W(W)) u_regs (
    .clk     (clk),
    .rst     (rst),
    .wr_a    (wr_a_i),
    .wr_b    (wr_b_i),
    .wr_data (wr_data_i),
    .dbuf_en (dbuf_en_i),
    .load    (evt.hit_b),
    .cmp_a_o (cmp_a),
    .cmp_b_o (cmp_b)
  );

  ppg_counter #(.W(W)) u_cnt (
    .clk   (clk),
    .rst   (rst),
    .run   (run_i),
    .tick  (tick_i),
    .cmp_a (cmp_a),
    .cmp_b (cmp_b),
    .evt_o (evt)
  );

  ppg_out_stage u_out (
    .clk      (clk),
    .rst      (rst),
    .run      (run_i),
    .mode     (mode),
    .pol      (pol_i),
    .evt      (evt),
    .irq_en_a (irq_en_a_i),
    .irq_en_b (irq_en_b_i),
    .pulse_o  (pulse_o),
    .irq_a_o  (irq_a_o),
    .irq_b_o  (irq_b_o)
  );

  // R10: reset clears all outputs
  assert_reset_outputs_R10: assert property (@(posedge clk)
    rst |=> (!pulse_o && !irq_a_o && !irq_b_o));
endmodule

// File: tb/tb_ppg_timer.sv
module tb_ppg_timer;
  localparam int W = 16;
  localparam int NV = 5;
  localparam int VA [NV] = '{2, 0, 3, 10, 1};
  localparam int VB [NV] = '{5, 7, 4, 30, 2};
  localparam int VP [NV] = '{0, 1, 0, 1, 0};
  localparam int VEA[NV] = '{1, 1, 0, 1, 1};
  localparam int VEB[NV] = '{1, 0, 1, 1, 1};

  logic clk = 0, rst = 1, tick_i = 0, run_i = 0, mode_i = 0, pol_i = 0;
  logic dbuf_en_i = 0, wr_a_i = 0, wr_b_i = 0, irq_en_a_i = 0, irq_en_b_i = 0;
  logic [W-1:0] wr_data_i = '0;
  logic pulse_o, irq_a_o, irq_b_o;

  int n_chk = 0, n_bad = 0;
  int hi, ia, ib;

  always #2.5 clk = ~clk;

  ppg_timer #(.W(W)) dut (.*);

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic chk(input int got, input int exp, input string req, input string what);
    n_chk++;
    if (got != exp) begin
      n_bad++;
      $display("FAIL %s %s: got %0d expected %0d", req, what, got, exp);
    end
  endtask

  task automatic wr(input bit to_b, input int val);
    wr_data_i = val[W-1:0];
    if (to_b) wr_b_i = 1; else wr_a_i = 1;
    step();
    wr_a_i = 0; wr_b_i = 0;
  endtask

  task automatic measure(input int n);
    hi = 0; ia = 0; ib = 0;
    for (int i = 0; i < n; i++) begin
      step();
      hi += pulse_o; ia += irq_a_o; ib += irq_b_o;
    end
  endtask

  task automatic stop();
    run_i = 0;
    step();
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) step();
    rst = 0;
    // R10: reset state
    chk(pulse_o, 0, "R10", "pulse after reset");
    chk(irq_a_o, 0, "R10", "irq_a after reset");
    chk(irq_b_o, 0, "R10", "irq_b after reset");

    // Vector table: pulse mode, tick every cycle, two periods each (R3, R4, R6)
    mode_i = 1; tick_i = 1;
    for (int v = 0; v < NV; v++) begin
      pol_i = VP[v][0];
      irq_en_a_i = VEA[v][0];
      irq_en_b_i = VEB[v][0];
      wr(0, VA[v]); wr(1, VB[v]);
      stop();
      chk(pulse_o, VP[v], "R4", "idle level before start");
      run_i = 1;
      measure(2 * (VB[v] + 1));
      chk(hi, 2 * (VP[v] != 0 ? (VA[v] + 1) : (VB[v] - VA[v])), "R3", "high samples over two periods");
      chk(ia, VEA[v] != 0 ? 2 : 0, "R6", "irq_a count");
      chk(ib, VEB[v] != 0 ? 2 : 0, "R6", "irq_b count");
      stop();
    end

    // R5 + R1: interval mode, tick on every other cycle
    begin
      int first = -1;
      mode_i = 0; pol_i = 0; irq_en_b_i = 1; irq_en_a_i = 0;
      wr(1, 4);
      stop();
      run_i = 1; hi = 0; ib = 0;
      for (int i = 0; i < 20; i++) begin
        tick_i = (i % 2 == 0);
        step();
        hi += pulse_o; ib += irq_b_o;
        if (irq_b_o && first < 0) first = i;
      end
      chk(first, 8, "R5", "edge index of first irq_b");
      chk(ib, 2, "R1", "irq_b count with half-rate tick");
      chk(hi, 0, "R5", "pulse stays idle in interval mode");
      tick_i = 1;
      stop();
    end

    // R7: direct write while stopped
    mode_i = 1; pol_i = 0; dbuf_en_i = 0;
    wr(1, 9); wr(0, 4);
    run_i = 1; measure(10);
    chk(hi, 5, "R7", "direct A write used at once");
    stop();

    // R8: buffered write takes effect after the next B match
    wr(0, 2);
    dbuf_en_i = 1;
    wr(0, 6);
    run_i = 1; measure(10);
    chk(hi, 7, "R8", "old A kept for current period");
    measure(10);
    chk(hi, 3, "R8", "shadow A used after boundary");
    dbuf_en_i = 0;
    stop();

    // R9: writes without ticks cause nothing
    tick_i = 0; run_i = 1; irq_en_a_i = 1; irq_en_b_i = 1;
    hi = 0; ia = 0; ib = 0;
    for (int i = 0; i < 6; i++) begin
      wr(i % 2 == 1, 0);
      hi += pulse_o; ia += irq_a_o; ib += irq_b_o;
    end
    chk(hi, 0, "R9", "pulse high samples with writes only");
    chk(ia + ib, 0, "R9", "interrupts with writes only");
    tick_i = 1;
    stop();

    // R2: stop mid-period then restart from zero
    wr(0, 2); wr(1, 5);
    run_i = 1; measure(4);
    pol_i = 1; stop();
    chk(pulse_o, 1, "R2", "idle level after mid-run stop");
    pol_i = 0; step();
    chk(pulse_o, 0, "R2", "idle level follows polarity");
    run_i = 1; measure(12);
    chk(hi, 6, "R2", "restart counts from zero");
    chk(ib, 2, "R2", "restart period count");

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule